// File: doc/BRIEF.md
# Dual-Clock Half-Width Read FIFO

This block is a first-in first-out buffer that connects two independent clock domains. Full 36-bit words are written on the write clock. They are handed out on the read clock as 18-bit halves, so every stored word takes two read transfers. Read and write pointers cross between the domains in Gray code through two-stage synchronizers. The depth is 256 words.

A single configuration pin, `modePin`, has two jobs. It is sampled on read-clock edges while reset is held. A HIGH level selects upper-half-first order and a LOW level selects lower-half-first order. After reset the pin must be held at a static level, which picks the timing mode. HIGH gives standard mode: the read flag reports empty and the write flag reports full. LOW gives fall-through mode: the first half of a word is shown without any read request, the read flag reports that output data is valid, and the write flag reports that space is available. Both flags are active LOW.

Programmable almost-empty and almost-full flags compare the word count against two offset inputs, which are held stable during operation. Each port transfers data only when its chip select is LOW and its enable is HIGH. The read data bus is released to high impedance while the read chip select is HIGH.

Top module: `halfsplit_fifo`

## Requirements
- R1: After reset in standard mode, `rdFlagN`=0 (empty), `wrFlagN`=1 (not full), `almostEmptyN`=0 and `almostFullN`=1. After reset in fall-through mode, `rdFlagN`=1 (not ready) and `wrFlagN`=0 (ready).
- R2: If `modePin` is HIGH during reset, bits [35:18] of each word are read out first and bits [17:0] second.
- R3: If `modePin` is LOW during reset, bits [17:0] of each word are read out first and bits [35:18] second.
- R4: In standard mode, a read request while the FIFO is not empty places the next half on `rdData` at that read-clock edge. A read request while `rdFlagN`=0 is ignored and `rdData` keeps its value.
- R5: In fall-through mode, the first half of a stored word appears on `rdData` with `rdFlagN`=0 and no read request. A read consumes the shown half and presents the next one. Without a read, `rdData` holds. `rdFlagN` returns to 1 once the last stored half has been consumed.
- R6: In standard mode, `wrFlagN` goes to 0 when 256 words are stored. Writes attempted while it is 0 are discarded.
- R7: `almostEmptyN` is 0 exactly when the number of words not yet completely read is at most `aeOffset`. A word with only one half read still counts.
- R8: `almostFullN` is 0 exactly when the free word slots (256 minus the stored count) are at most `afOffset`.
- R9: A read with `rdCsN`=1 consumes nothing and `rdData` is high impedance. A write with `wrCsN`=1 stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock, independent of wrClk |
| rstN | input | 1 | Asynchronous active-LOW reset for both sides |
| modePin | input | 1 | During reset: half order (1 = upper first). After reset: timing (1 = standard, 0 = fall-through) |
| wrCsN | input | 1 | Write chip select, active LOW |
| wrEn | input | 1 | Write enable, active HIGH |
| wrData | input | 36 | Write word |
| wrFlagN | output | 1 | Standard: LOW = full. Fall-through: LOW = space available |
| almostFullN | output | 1 | LOW when free slots are at most afOffset |
| afOffset | input | 8 | Almost-full threshold |
| rdCsN | input | 1 | Read chip select, active LOW; HIGH floats rdData |
| rdEn | input | 1 | Read enable, active HIGH |
| rdData | output | 18 | Read half-word |
| rdFlagN | output | 1 | Standard: LOW = empty. Fall-through: LOW = output valid |
| almostEmptyN | output | 1 | LOW when stored words are at most aeOffset |
| aeOffset | input | 8 | Almost-empty threshold |

## Verification
Two events can land on the same read-clock edge: the consumption of the first half of a word and a change in the almost-empty comparison. They only appear to coincide, because the count must not drop until the second half is taken. The bench stores exactly one word more than `aeOffset` and reads one half at a time. It expects `almostEmptyN` to stay HIGH after the first half and to fall on the same edge that delivers the second half. The same coincidence is checked at the full boundary, where the last accepted write and the full flag fall on one write edge and a write on the next edge must be dropped.

// File: rtl/halfsplit_pkg.sv
package halfsplit_pkg;
  // Strobes from the control block to the datapath
  typedef struct packed {
    logic wrStb;     // store wrData at wrAddr (write clock)
    logic loadOut;   // load one half into the output register (read clock)
    logic upperSel;  // 1: that half is bits [DATA_W-1:HALF_W]
  } strobe_t;
endpackage

// File: rtl/halfsplit_ctrl.sv
module halfsplit_ctrl
  import halfsplit_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          modePin,
  input  logic          wrCsN,
  input  logic          wrEn,
  input  logic          rdCsN,
  input  logic          rdEn,
  input  logic [AW-1:0] aeOffset,
  input  logic [AW-1:0] afOffset,
  output strobe_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          wrFlagN,
  output logic          almostFullN,
  output logic          rdFlagN,
  output logic          almostEmptyN
);
  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic fwft;
  assign fwft = !modePin;

  // ---------------- write domain ----------------
  logic [PW-1:0] wrPtr, wrGray, rdGrayS1, rdGrayS2;
  logic [PW-1:0] wrNext, rdPtrW, wrCount, freeSlots;
  logic          isFull;

  assign wrNext    = wrPtr + 1'b1;
  assign rdPtrW    = fromGray(rdGrayS2);
  assign wrCount   = wrPtr - rdPtrW;
  assign isFull    = (wrCount == PW'(DEPTH));
  assign freeSlots = PW'(DEPTH) - wrCount;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrPtr    <= '0;
      wrGray   <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (stb.wrStb) begin
        wrPtr  <= wrNext;
        wrGray <= toGray(wrNext);
      end
    end
  end

  assign wrFlagN     = fwft ? isFull : !isFull;
  assign almostFullN = !(freeSlots <= {1'b0, afOffset});
  assign wrAddr      = wrPtr[AW-1:0];

  // ---------------- read domain ----------------
  logic [PW-1:0] rdWordPtr, rdGray, wrGrayS1, wrGrayS2;
  logic [PW-1:0] rdNext, wrPtrR, rdCount;
  logic          halfSel, outValid, bigEnd, avail, readReq;

  assign rdNext  = rdWordPtr + 1'b1;
  assign wrPtrR  = fromGray(wrGrayS2);
  assign rdCount = wrPtrR - rdWordPtr;
  assign avail   = (rdCount != '0);
  assign readReq = !rdCsN && rdEn;

  // Order pin captured on read-clock edges while reset is held
  always_ff @(posedge rdClk) begin
    if (!rstN) bigEnd <= modePin;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdWordPtr <= '0;
      rdGray    <= '0;
      wrGrayS1  <= '0;
      wrGrayS2  <= '0;
      halfSel   <= 1'b0;
      outValid  <= 1'b0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (stb.loadOut) begin
        halfSel  <= !halfSel;
        outValid <= 1'b1;
        if (halfSel) begin
          rdWordPtr <= rdNext;
          rdGray    <= toGray(rdNext);
        end
      end else if (readReq) begin
        outValid <= 1'b0;
      end
    end
  end

  always_comb begin
    stb.wrStb    = !wrCsN && wrEn && !isFull;
    stb.loadOut  = fwft ? (avail && (!outValid || readReq)) : (avail && readReq);
    stb.upperSel = bigEnd ^ halfSel;
  end

  assign rdFlagN      = fwft ? !outValid : avail;
  assign almostEmptyN = !(rdCount <= {1'b0, aeOffset});
  assign rdAddr       = rdWordPtr[AW-1:0];
endmodule

// File: rtl/halfsplit_data.sv
module halfsplit_data
  import halfsplit_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [AW-1:0]     rdAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdCsN,
  output logic [HALF_W-1:0] rdData
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [DATA_W-1:0] rdWord;
  logic [HALF_W-1:0] outReg;

  always_ff @(posedge wrClk) begin
    if (stb.wrStb) store[wrAddr] <= wrData;
  end

  assign rdWord = store[rdAddr];

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) outReg <= '0;
    else if (stb.loadOut)
      outReg <= stb.upperSel ? rdWord[DATA_W-1:HALF_W] : rdWord[HALF_W-1:0];
  end

  assign rdData = rdCsN ? {HALF_W{1'bz}} : outReg;
endmodule

// File: rtl/halfsplit_fifo.sv
module halfsplit_fifo
  import halfsplit_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int DEPTH  = 256,
  localparam int AW     = $clog2(DEPTH),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              modePin,
  input  logic              wrCsN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrFlagN,
  output logic              almostFullN,
  input  logic [AW-1:0]     afOffset,
  input  logic              rdCsN,
  input  logic              rdEn,
  output logic [HALF_W-1:0] rdData,
  output logic              rdFlagN,
  output logic              almostEmptyN,
  input  logic [AW-1:0]     aeOffset
);
  strobe_t       stb;
  logic [AW-1:0] wrAddr, rdAddr;

  halfsplit_ctrl #(.DEPTH(DEPTH)) ctrl_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modePin(modePin),
    .wrCsN(wrCsN), .wrEn(wrEn), .rdCsN(rdCsN), .rdEn(rdEn),
    .aeOffset(aeOffset), .afOffset(afOffset), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrFlagN(wrFlagN),
    .almostFullN(almostFullN), .rdFlagN(rdFlagN), .almostEmptyN(almostEmptyN)
  );

  halfsplit_data #(.DATA_W(DATA_W), .DEPTH(DEPTH)) data_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .stb(stb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdCsN(rdCsN), .rdData(rdData)
  );
endmodule

// File: rtl/halfsplit_chk.sv
module halfsplit_chk
  import halfsplit_pkg::*;
#(
  parameter int HALF_W = 18
) (
  input logic              wrClk,
  input logic              rdClk,
  input logic              rstN,
  input logic              modePin,
  input logic              wrFlagN,
  input logic              almostFullN,
  input logic              rdCsN,
  input logic              rdEn,
  input logic [HALF_W-1:0] rdData,
  input logic              rdFlagN,
  input logic              almostEmptyN,
  input strobe_t           stb
);
  AST_EMPTY_READ_HOLDS: assert property (@(posedge rdClk) disable iff (!rstN)
    (modePin && !rdFlagN && !rdCsN && rdEn) |=> (rdCsN || $stable(rdData))); // R4

  AST_FWFT_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    (!modePin && !rdFlagN && !rdCsN && !rdEn) |=> (!rdFlagN && (rdCsN || $stable(rdData)))); // R5

  AST_FULL_BLOCKS_WRITE: assert property (@(posedge wrClk) disable iff (!rstN)
    (modePin && !wrFlagN) |-> !stb.wrStb); // R6

  AST_EMPTY_MEANS_ALMOST_EMPTY: assert property (@(posedge rdClk) disable iff (!rstN)
    (modePin && !rdFlagN) |-> !almostEmptyN); // R7

  AST_FULL_MEANS_ALMOST_FULL: assert property (@(posedge wrClk) disable iff (!rstN)
    (modePin && !wrFlagN) |-> !almostFullN); // R8

  AST_CS_BLOCKS_READ: assert property (@(posedge rdClk) disable iff (!rstN)
    (modePin && rdCsN) |-> !stb.loadOut); // R9
endmodule

bind halfsplit_fifo halfsplit_chk #(.HALF_W(HALF_W)) chk_i (
  .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modePin(modePin),
  .wrFlagN(wrFlagN), .almostFullN(almostFullN), .rdCsN(rdCsN), .rdEn(rdEn),
  .rdData(rdData), .rdFlagN(rdFlagN), .almostEmptyN(almostEmptyN), .stb(stb)
);

// File: tb/halfsplit_fifo_tb.sv
`timescale 1ns/1ps
module halfsplit_fifo_tb_top;
  logic        wrClk = 0, rdClk = 0, rstN = 0, modePin = 1;
  logic        wrCsN = 0, wrEn = 0, rdCsN = 0, rdEn = 0;
  logic [35:0] wrData = '0;
  logic [7:0]  afOffset = 8'd3, aeOffset = 8'd2;
  logic [17:0] rdData;
  logic        wrFlagN, almostFullN, rdFlagN, almostEmptyN;
  int          nRun = 0, nFail = 0;

  always #2.5 wrClk = ~wrClk;   // 200 MHz
  always #3.5 rdClk = ~rdClk;

  halfsplit_fifo dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .modePin(modePin),
    .wrCsN(wrCsN), .wrEn(wrEn), .wrData(wrData), .wrFlagN(wrFlagN),
    .almostFullN(almostFullN), .afOffset(afOffset), .rdCsN(rdCsN), .rdEn(rdEn),
    .rdData(rdData), .rdFlagN(rdFlagN), .almostEmptyN(almostEmptyN), .aeOffset(aeOffset)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doReset(input logic pinDuring, input logic pinAfter);
    wrEn = 0; rdEn = 0; wrCsN = 0; rdCsN = 0;
    rstN = 0; modePin = pinDuring;
    repeat (4) @(negedge rdClk);
    @(negedge wrClk) rstN = 1;
    modePin = pinAfter;
    repeat (3) @(negedge rdClk);
  endtask

  task automatic writeWord(input logic csn, input logic [35:0] d);
    @(negedge wrClk) begin wrCsN = csn; wrEn = 1; wrData = d; end
    @(negedge wrClk) begin wrEn = 0; wrCsN = 0; end
  endtask

  task automatic readHalf(input logic csn, output logic [17:0] d);
    @(negedge rdClk) begin rdCsN = csn; rdEn = 1; end
    @(negedge rdClk) begin rdEn = 0; rdCsN = 0; end
    d = rdData;
  endtask

  task automatic settle();
    repeat (6) @(negedge wrClk);
    repeat (6) @(negedge rdClk);
  endtask

  function automatic logic [35:0] pat(input int i);
    return {18'(i ^ 18'h155), 18'(i + 18'h100)};
  endfunction

  localparam logic [35:0] W1 = {18'h12345, 18'h0ABCD};
  localparam logic [35:0] W2 = {18'h3FFFE, 18'h00001};
  localparam logic [35:0] W3 = {18'h2D2D2, 18'h1E1E1};

  task automatic testResetStd();
    doReset(1, 1);
    check(rdFlagN == 0, "R1 std rdFlagN", 36'(rdFlagN), 36'd0);
    check(wrFlagN == 1, "R1 std wrFlagN", 36'(wrFlagN), 36'd1);
    check(almostEmptyN == 0 && almostFullN == 1, "R1 std almost flags",
          {34'd0, almostEmptyN, almostFullN}, 36'd1);
  endtask

  task automatic testUpperFirst();
    logic [17:0] d;
    writeWord(0, W1); writeWord(0, W2); settle();
    check(rdFlagN == 1, "R4 not empty", 36'(rdFlagN), 36'd1);
    readHalf(0, d); check(d == W1[35:18], "R2 w1 first", 36'(d), 36'(W1[35:18]));
    readHalf(0, d); check(d == W1[17:0],  "R2 w1 second", 36'(d), 36'(W1[17:0]));
    readHalf(0, d); check(d == W2[35:18], "R2 w2 first", 36'(d), 36'(W2[35:18]));
    readHalf(0, d); check(d == W2[17:0],  "R2 w2 second", 36'(d), 36'(W2[17:0]));
    check(rdFlagN == 0, "R4 empty after drain", 36'(rdFlagN), 36'd0);
  endtask

  task automatic testEmptyRead();
    logic [17:0] d;
    readHalf(0, d);
    check(d == W2[17:0], "R4 empty read ignored", 36'(d), 36'(W2[17:0]));
    check(rdFlagN == 0, "R4 still empty", 36'(rdFlagN), 36'd0);
  endtask

  task automatic testChipSelect();
    logic [17:0] d;
    writeWord(0, W3); writeWord(1, W1); settle();
    readHalf(1, d);                       // deselected: nothing consumed
    readHalf(0, d); check(d == W3[35:18], "R9 cs read not consumed", 36'(d), 36'(W3[35:18]));
    readHalf(0, d); check(d == W3[17:0],  "R9 second half", 36'(d), 36'(W3[17:0]));
    check(rdFlagN == 0, "R9 deselected write dropped", 36'(rdFlagN), 36'd0);
  endtask

  task automatic testAlmostEmpty();
    logic [17:0] d;
    writeWord(0, W1); writeWord(0, W2); writeWord(0, W3); settle();
    check(almostEmptyN == 1, "R7 three words above offset", 36'(almostEmptyN), 36'd1);
    readHalf(0, d);
    check(almostEmptyN == 1, "R7 half-read word still counts", 36'(almostEmptyN), 36'd1);
    readHalf(0, d);
    check(almostEmptyN == 0, "R7 two words at offset", 36'(almostEmptyN), 36'd0);
    repeat (4) readHalf(0, d);
    check(rdFlagN == 0, "R7 drained", 36'(rdFlagN), 36'd0);
  endtask

  task automatic testFull();
    logic [17:0] d;
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      writeWord(0, pat(i));
      if (i == 251) check(almostFullN == 1, "R8 four free", 36'(almostFullN), 36'd1);
      if (i == 252) check(almostFullN == 0, "R8 three free", 36'(almostFullN), 36'd0);
      if (i == 254) check(wrFlagN == 1, "R6 one free not full", 36'(wrFlagN), 36'd1);
    end
    check(wrFlagN == 0, "R6 full at depth", 36'(wrFlagN), 36'd0);
    writeWord(0, 36'h0);                  // must be discarded
    settle();
    for (int i = 0; i < 256; i++) begin
      readHalf(0, d); if (d != pat(i)[35:18]) bad++;
      readHalf(0, d); if (d != pat(i)[17:0])  bad++;
    end
    check(bad == 0, "R6 data order through full", 36'(bad), 36'd0);
    check(rdFlagN == 0, "R6 extra write dropped", 36'(rdFlagN), 36'd0);
    settle();
    check(wrFlagN == 1, "R6 not full after drain", 36'(wrFlagN), 36'd1);
  endtask

  task automatic testFallThroughLower();
    logic [17:0] d;
    doReset(0, 0);
    check(rdFlagN == 1 && wrFlagN == 0, "R1 fwft flags", {34'd0, rdFlagN, wrFlagN}, 36'h2);
    writeWord(0, W1); settle();
    check(rdFlagN == 0, "R5 output ready", 36'(rdFlagN), 36'd0);
    check(rdData == W1[17:0], "R3 R5 lower shown first", 36'(rdData), 36'(W1[17:0]));
    readHalf(0, d); check(d == W1[35:18], "R5 next half after read", 36'(d), 36'(W1[35:18]));
    check(rdFlagN == 0, "R5 ready for second half", 36'(rdFlagN), 36'd0);
    readHalf(0, d);
    check(rdFlagN == 1, "R5 not ready after last", 36'(rdFlagN), 36'd1);
  endtask

  task automatic testStdLower();
    logic [17:0] d;
    doReset(0, 1);
    writeWord(0, W2); settle();
    readHalf(0, d); check(d == W2[17:0],  "R3 lower first std", 36'(d), 36'(W2[17:0]));
    readHalf(0, d); check(d == W2[35:18], "R3 upper second std", 36'(d), 36'(W2[35:18]));
  endtask

  initial begin
    repeat (150000) @(posedge wrClk);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    testResetStd();
    testUpperFirst();
    testEmptyRead();
    testChipSelect();
    testAlmostEmpty();
    testFull();
    testFallThroughLower();
    testStdLower();
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule